// File: doc/BRIEF.md
# SMBus Host Transaction Engine

This block is the command side of an SMBus host controller. It sits behind a small byte-wide register port. Software writes the target address and direction, a command byte, up to two data bytes and a protocol code. It then sets a launch bit. The engine runs the whole transaction by issuing a series of byte-level primitives (start, write byte, read byte, repeated start, stop) to a bus port. That port handles bit timing and reports, for each primitive, whether the target acknowledged and whether arbitration was lost.

Read results come back in the data registers. Block payloads pass through a 32-entry buffer inside the engine, reached at a single auto-incrementing offset. The outcome is reported in sticky write-one-to-clear flags, which can drive an interrupt line.

The sequencer is one state machine with these states:
- `S_IDLE` waits for a launch.
- `S_CHECK` rejects a bad protocol code or block count without touching the bus.
- `S_START` sends the start primitive.
- `S_ADDR` sends the address byte.
- `S_CMD` sends the command byte.
- `S_WDATA` sends the data bytes.
- `S_RSTART` sends the repeated start.
- `S_RADDR` sends the address again with the read direction.
- `S_RDATA` reads the data bytes.
- `S_STOP` sends the stop primitive.

Transitions:
- `IDLE→CHECK` on an accepted launch.
- `CHECK→START` when the request is valid; `CHECK→IDLE` when it is rejected.
- Each primitive state leaves only when the port signals completion.
- A nack goes to `S_STOP`.
- Lost arbitration goes straight back to `S_IDLE`.
- Every other completion follows the sequence of the protocol.

Top module: `smbus_host_engine`

## Requirements
- R1: Register offsets are:
  - 0 status: bit0 busy, bit1 done, bit2 no-response, bit3 collision, bit4 failed.
  - 2 control: bits 4:2 protocol, bit0 interrupt enable; a read returns only those bits.
  - 3 command.
  - 4 address.
  - 5 data0.
  - 6 data1.
  - 7 block port.
  
  Offset 1 and every other bit read zero, and all registers reset to zero.
- R2: Writing control with bit6 set launches a transaction only when the engine is idle and status bits 2 to 4 are all clear. Busy reads 1 from the launch until the sequence ends. While busy, writes to control and to offsets 3 to 7 are ignored.
- R3: Primitive codes are 0 start, 1 write, 2 read, 3 repeated start and 4 stop. Each request is a one-cycle `prim_req` pulse. The first byte after start carries the address register. A quick command (protocol 000) issues start, address, stop.
- R4: Protocol 001 writes the command byte as its only data byte. When read, it reads one byte with `prim_last` high (nack) into data0.
- R5: Writes of protocol 010 (byte data) and 011 (word data) send start, address, command, data0, then data1 for word data, then stop.
- R6: Reads of protocols 010, 011 and 101 send start, the address with bit0 cleared, the command, repeated start and the address with bit0 set. They then read the data, with `prim_last` high only on the final byte, and stop. Word data returns the low byte in data0 and the high byte in data1.
- R7: A block write (101) with data0 outside 1..32 sets failed and issues no primitive. Otherwise it sends data0 as a count byte, then that many buffer bytes in the order they were loaded.
- R8: A block read stores the first byte read in data0 as the count. A count outside 1..32 sets failed and goes straight to stop. A valid count fills the buffer with that many payload bytes.
- R9: Each write or read at offset 7 moves the buffer pointer to the next entry. Any read of control sets it back to the first entry.
- R10: A nack of any written byte sets bit2 and ends the transaction with stop.
- R11: Lost arbitration on any primitive sets bit3 and ends the transaction without stop.
- R12: Protocol codes 100, 110 and 111 set failed and issue no primitive.
- R13: Done (bit1) sets whenever a launched transaction ends. Writing 1 to a status bit clears only that bit.
- R14: `irq` is high exactly when control bit0 is set and any of done, no-response, collision or failed is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at offsets 2 and 7) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |
| prim_req | output | 1 | One-cycle primitive request |
| prim_op | output | 3 | Primitive code, valid with `prim_req` |
| prim_wdata | output | 8 | Byte to send on a write primitive |
| prim_last | output | 1 | On a read primitive: nack this byte |
| prim_done | input | 1 | Primitive completed (one cycle) |
| prim_nack | input | 1 | Target did not acknowledge the written byte |
| prim_arb | input | 1 | Arbitration was lost during the primitive |
| prim_rdata | input | 8 | Byte received by a read primitive |

## Verification
The assertions take three things for granted about the bus port:
- `prim_done` is a single-cycle pulse, and it arrives only after a request and at least one cycle later.
- `prim_nack` is raised only together with `prim_done` on a write primitive.
- The register strobes are never both high in one cycle.

The bench's target model answers every request after a fixed two-cycle delay. It raises nack or arbitration loss only at the one primitive index a test selects, and it drives the register port one access at a time. Every state path is therefore reached only through legal port behaviour.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_WRITE  = 3'd1,
        OP_READ   = 3'd2,
        OP_RSTART = 3'd3,
        OP_STOP   = 3'd4
    } prim_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_START, S_ADDR, S_CMD,
        S_WDATA, S_RSTART, S_RADDR, S_RDATA, S_STOP
    } seq_state_e;

    localparam logic [2:0] PR_QUICK = 3'b000;
    localparam logic [2:0] PR_BYTE  = 3'b001;
    localparam logic [2:0] PR_BDATA = 3'b010;
    localparam logic [2:0] PR_WORD  = 3'b011;
    localparam logic [2:0] PR_BLOCK = 3'b101;

    localparam logic [2:0] OFS_STAT = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_CMD  = 3'd3;
    localparam logic [2:0] OFS_ADDR = 3'd4;
    localparam logic [2:0] OFS_D0   = 3'd5;
    localparam logic [2:0] OFS_D1   = 3'd6;
    localparam logic [2:0] OFS_BLK  = 3'd7;

endpackage

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic          host_adv,
    input  logic          host_rewind,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [PW-1:0] host_ptr,
    input  logic          eng_we,
    input  logic [PW-1:0] eng_widx,
    input  logic [DW-1:0] eng_wdata,
    input  logic [PW-1:0] eng_ridx,
    output logic [DW-1:0] eng_rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] ptr_q;

    // Host pointer: a control read rewinds, a port access steps forward.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (host_rewind) begin
            ptr_q <= '0;
        end else if (host_we || host_adv) begin
            ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (eng_we && eng_widx == PW'(g)) begin
                mem[g] <= eng_wdata;
            end else if (host_we && ptr_q == PW'(g)) begin
                mem[g] <= host_wdata;
            end
        end
    end

    assign host_rdata = mem[ptr_q];
    assign host_ptr   = ptr_q;
    assign eng_rdata  = mem[eng_ridx];

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
    import smbus_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int PW = $clog2(BUF_DEPTH),
    localparam int IW = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [2:0]    prot,
    input  logic [7:0]    addr_b,
    input  logic [7:0]    cmd_b,
    input  logic [7:0]    d0,
    input  logic [7:0]    d1,
    input  logic [7:0]    buf_rdata,
    output logic [PW-1:0] buf_ridx,
    output logic [PW-1:0] buf_widx,
    output logic          buf_we,
    output logic          ld_d0,
    output logic          ld_d1,
    output logic          prim_req,
    output logic [2:0]    prim_op,
    output logic [7:0]    prim_wdata,
    output logic          prim_last,
    input  logic          prim_done,
    input  logic          prim_nack,
    input  logic          prim_arb,
    input  logic [7:0]    prim_rdata,
    output logic          set_nack,
    output logic          set_coll,
    output logic          set_fail,
    output logic          set_done,
    output logic          busy
);
    seq_state_e    state, nxt;
    logic          issued;
    logic [IW-1:0] idx;
    logic          idx_clr, idx_inc;

    function automatic logic count_ok(input logic [7:0] v);
        return (v != 8'd0) && (v <= 8'(BUF_DEPTH));
    endfunction

    logic       is_rd, is_blk, combo, prot_ok, at_last;
    logic [7:0] last_v;

    assign is_rd   = addr_b[0];
    assign is_blk  = (prot == PR_BLOCK);
    assign combo   = is_rd && (prot == PR_BDATA || prot == PR_WORD || is_blk);
    assign prot_ok = (prot == PR_QUICK) || (prot == PR_BYTE) || (prot == PR_BDATA)
                     || (prot == PR_WORD) || is_blk;
    assign last_v  = (prot == PR_WORD) ? 8'd1 : (is_blk ? d0 : 8'd0);
    assign at_last = (8'(idx) == last_v) && !(is_blk && is_rd && idx == '0);

    assign buf_ridx = PW'(idx - 1'b1);
    assign buf_widx = PW'(idx - 1'b1);
    assign busy     = (state != S_IDLE);

    // State register, request tracker and byte index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            issued <= 1'b0;
            idx    <= '0;
        end else begin
            state <= nxt;
            if (prim_done)     issued <= 1'b0;
            else if (prim_req) issued <= 1'b1;
            if (idx_clr)       idx <= '0;
            else if (idx_inc)  idx <= idx + 1'b1;
        end
    end

    // Next state and all outputs.
    always_comb begin
        nxt        = state;
        prim_req   = 1'b0;
        prim_op    = OP_START;
        prim_wdata = 8'h00;
        prim_last  = 1'b0;
        set_nack   = 1'b0;
        set_coll   = 1'b0;
        set_fail   = 1'b0;
        set_done   = 1'b0;
        ld_d0      = 1'b0;
        ld_d1      = 1'b0;
        buf_we     = 1'b0;
        idx_clr    = 1'b0;
        idx_inc    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (go) nxt = S_CHECK;
            end
            S_CHECK: begin
                if (!prot_ok || (is_blk && !is_rd && !count_ok(d0))) begin
                    set_fail = 1'b1;
                    set_done = 1'b1;
                    nxt      = S_IDLE;
                end else begin
                    nxt = S_START;
                end
            end
            S_START, S_RSTART: begin
                prim_req = !issued;
                prim_op  = (state == S_START) ? OP_START : OP_RSTART;
                if (prim_done) begin
                    if (prim_arb) begin
                        set_coll = 1'b1;
                        set_done = 1'b1;
                        nxt      = S_IDLE;
                    end else begin
                        nxt = (state == S_START) ? S_ADDR : S_RADDR;
                    end
                end
            end
            S_ADDR, S_CMD, S_WDATA, S_RADDR: begin
                prim_req = !issued;
                prim_op  = OP_WRITE;
                unique case (state)
                    S_ADDR:  prim_wdata = combo ? {addr_b[7:1], 1'b0} : addr_b;
                    S_CMD:   prim_wdata = cmd_b;
                    S_RADDR: prim_wdata = {addr_b[7:1], 1'b1};
                    default: prim_wdata = (idx == '0) ? d0 : (is_blk ? buf_rdata : d1);
                endcase
                if (prim_done) begin
                    if (prim_arb) begin
                        set_coll = 1'b1;
                        set_done = 1'b1;
                        nxt      = S_IDLE;
                    end else if (prim_nack) begin
                        set_nack = 1'b1;
                        nxt      = S_STOP;
                    end else begin
                        unique case (state)
                            S_ADDR: begin
                                idx_clr = 1'b1;
                                if (prot == PR_QUICK)              nxt = S_STOP;
                                else if (prot == PR_BYTE && is_rd) nxt = S_RDATA;
                                else                               nxt = S_CMD;
                            end
                            S_CMD: begin
                                idx_clr = 1'b1;
                                if (prot == PR_BYTE) nxt = S_STOP;
                                else if (combo)      nxt = S_RSTART;
                                else                 nxt = S_WDATA;
                            end
                            S_RADDR: begin
                                idx_clr = 1'b1;
                                nxt     = S_RDATA;
                            end
                            default: begin
                                if (at_last) nxt = S_STOP;
                                else         idx_inc = 1'b1;
                            end
                        endcase
                    end
                end
            end
            S_RDATA: begin
                prim_req  = !issued;
                prim_op   = OP_READ;
                prim_last = at_last;
                if (prim_done) begin
                    if (prim_arb) begin
                        set_coll = 1'b1;
                        set_done = 1'b1;
                        nxt      = S_IDLE;
                    end else begin
                        if (idx == '0)   ld_d0  = 1'b1;
                        else if (is_blk) buf_we = 1'b1;
                        else             ld_d1  = 1'b1;
                        if (is_blk && idx == '0 && !count_ok(prim_rdata)) begin
                            set_fail = 1'b1;
                            nxt      = S_STOP;
                        end else if (at_last) begin
                            nxt = S_STOP;
                        end else begin
                            idx_inc = 1'b1;
                        end
                    end
                end
            end
            S_STOP: begin
                prim_req = !issued;
                prim_op  = OP_STOP;
                if (prim_done) begin
                    set_coll = prim_arb;
                    set_done = 1'b1;
                    nxt      = S_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/smbus_host_engine.sv
module smbus_host_engine
    import smbus_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       prim_req,
    output logic [2:0] prim_op,
    output logic [7:0] prim_wdata,
    output logic       prim_last,
    input  logic       prim_done,
    input  logic       prim_nack,
    input  logic       prim_arb,
    input  logic [7:0] prim_rdata
);
    localparam int PW = $clog2(BUF_DEPTH);

    logic [2:0]    ctrl_prot;
    logic          ctrl_ie;
    logic [7:0]    cmd_q, addr_q, d0_q, d1_q;
    logic          st_nack, st_coll, st_fail, st_done;
    logic          busy, go;
    logic          ld_d0, ld_d1, buf_we;
    logic          set_nack, set_coll, set_fail, set_done;
    logic [PW-1:0] buf_ridx, buf_widx, blk_ptr;
    logic [7:0]    buf_rdata, host_rdata;

    function automatic logic hit(input logic [2:0] a, input logic [2:0] o);
        return a == o;
    endfunction

    logic wr_ok, st_wr;
    assign wr_ok = reg_wr && !busy;
    assign st_wr = reg_wr && hit(reg_addr, OFS_STAT);
    assign go    = reg_wr && hit(reg_addr, OFS_CTRL) && reg_wdata[6] && !busy
                   && !(st_nack || st_coll || st_fail);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_prot <= '0;
            ctrl_ie   <= 1'b0;
            cmd_q     <= '0;
            addr_q    <= '0;
            d0_q      <= '0;
            d1_q      <= '0;
        end else begin
            if (wr_ok && hit(reg_addr, OFS_CTRL)) begin
                ctrl_prot <= reg_wdata[4:2];
                ctrl_ie   <= reg_wdata[0];
            end
            if (wr_ok && hit(reg_addr, OFS_CMD))  cmd_q  <= reg_wdata;
            if (wr_ok && hit(reg_addr, OFS_ADDR)) addr_q <= reg_wdata;
            if (ld_d0)                                 d0_q <= prim_rdata;
            else if (wr_ok && hit(reg_addr, OFS_D0))   d0_q <= reg_wdata;
            if (ld_d1)                                 d1_q <= prim_rdata;
            else if (wr_ok && hit(reg_addr, OFS_D1))   d1_q <= reg_wdata;
        end
    end

    // Sticky flags: a set from the sequencer wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            st_nack <= 1'b0;
            st_coll <= 1'b0;
            st_fail <= 1'b0;
        end else begin
            st_done <= set_done | (st_done & ~(st_wr & reg_wdata[1]));
            st_nack <= set_nack | (st_nack & ~(st_wr & reg_wdata[2]));
            st_coll <= set_coll | (st_coll & ~(st_wr & reg_wdata[3]));
            st_fail <= set_fail | (st_fail & ~(st_wr & reg_wdata[4]));
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_STAT: reg_rdata = {3'b000, st_fail, st_coll, st_nack, st_done, busy};
            OFS_CTRL: reg_rdata = {3'b000, ctrl_prot, 1'b0, ctrl_ie};
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_ADDR: reg_rdata = addr_q;
            OFS_D0:   reg_rdata = d0_q;
            OFS_D1:   reg_rdata = d1_q;
            OFS_BLK:  reg_rdata = host_rdata;
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign irq = ctrl_ie & (st_done | st_nack | st_coll | st_fail);

    smbus_blkbuf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (wr_ok && hit(reg_addr, OFS_BLK)),
        .host_adv    (reg_rd && hit(reg_addr, OFS_BLK)),
        .host_rewind (reg_rd && hit(reg_addr, OFS_CTRL)),
        .host_wdata  (reg_wdata),
        .host_rdata  (host_rdata),
        .host_ptr    (blk_ptr),
        .eng_we      (buf_we),
        .eng_widx    (buf_widx),
        .eng_wdata   (prim_rdata),
        .eng_ridx    (buf_ridx),
        .eng_rdata   (buf_rdata)
    );

    smbus_seq #(.BUF_DEPTH(BUF_DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .prot       (ctrl_prot),
        .addr_b     (addr_q),
        .cmd_b      (cmd_q),
        .d0         (d0_q),
        .d1         (d1_q),
        .buf_rdata  (buf_rdata),
        .buf_ridx   (buf_ridx),
        .buf_widx   (buf_widx),
        .buf_we     (buf_we),
        .ld_d0      (ld_d0),
        .ld_d1      (ld_d1),
        .prim_req   (prim_req),
        .prim_op    (prim_op),
        .prim_wdata (prim_wdata),
        .prim_last  (prim_last),
        .prim_done  (prim_done),
        .prim_nack  (prim_nack),
        .prim_arb   (prim_arb),
        .prim_rdata (prim_rdata),
        .set_nack   (set_nack),
        .set_coll   (set_coll),
        .set_fail   (set_fail),
        .set_done   (set_done),
        .busy       (busy)
    );

endmodule

// File: rtl/smbus_host_checks.sv
module smbus_host_checks
    import smbus_host_pkg::*;
#(
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [2:0]    reg_addr,
    input logic          start_bit,
    input logic          busy,
    input logic          st_nack,
    input logic          st_coll,
    input logic          st_fail,
    input logic          prim_req,
    input logic [2:0]    prim_op,
    input logic          prim_done,
    input logic          prim_nack,
    input logic          prim_arb,
    input logic [PW-1:0] blk_ptr
);
    // R2: a launch with a flag still pending leaves the engine idle.
    a_r2_launch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTRL && start_bit && !busy
         && (st_nack || st_coll || st_fail)) |=> !busy);

    // R3: each primitive request is a single-cycle pulse.
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prim_req |=> !prim_req);

    // R10: a nacked write raises the flag and the next request is stop.
    a_r10_nack_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_done && prim_nack && !prim_arb && prim_op == OP_WRITE) |=> st_nack);

    a_r10_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_done && prim_nack && !prim_arb && prim_op == OP_WRITE)
        |=> (prim_req && prim_op == OP_STOP));

    // R11: lost arbitration flags a collision and frees the engine at once.
    a_r11_arb_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_done && prim_arb) |=> (st_coll && !busy));

    // R9: a control read rewinds the block pointer.
    a_r9_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_CTRL) |=> (blk_ptr == '0));

endmodule

bind smbus_host_engine smbus_host_checks #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .start_bit (reg_wdata[6]),
    .busy      (busy),
    .st_nack   (st_nack),
    .st_coll   (st_coll),
    .st_fail   (st_fail),
    .prim_req  (prim_req),
    .prim_op   (prim_op),
    .prim_done (prim_done),
    .prim_nack (prim_nack),
    .prim_arb  (prim_arb),
    .blk_ptr   (blk_ptr)
);

// File: tb/sim_smbus_host_engine.sv
`timescale 1ns/1ps
module sim_smbus_host_engine;
    import smbus_host_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, prim_req, prim_last;
    logic [2:0] prim_op;
    logic [7:0] prim_wdata;
    logic       prim_done = 1'b0, prim_nack = 1'b0, prim_arb = 1'b0;
    logic [7:0] prim_rdata = 8'h00;

    always #5 clk = ~clk;

    smbus_host_engine u0 (.*);

    int n_chk = 0, n_fail = 0;
    int log_op [64];
    int log_b  [64];
    int n_log = 0;
    int exp_op [64];
    int exp_b  [64];
    int n_exp = 0;
    int wr_cnt = 0, rd_cnt = 0, prim_cnt = 0;
    int nack_sel = -1, arb_sel = -1;
    int blk_rsp = 0;
    bit model_blk = 0;
    bit done_flag = 0;

    localparam logic [6:0] TGT = 7'h2A;
    localparam logic [7:0] CMD = 8'h71;

    function automatic logic [7:0] pat(input int k);
        return 8'(8'h5C + 37 * k);
    endfunction

    // Bus-port model: answers each request two cycles later.
    initial begin
        forever begin
            @(negedge clk);
            prim_done = 1'b0; prim_nack = 1'b0; prim_arb = 1'b0;
            if (prim_req === 1'b1) begin
                int op, b;
                op = int'(prim_op);
                b  = (prim_op == OP_WRITE) ? int'(prim_wdata)
                   : (prim_op == OP_READ) ? int'(prim_last) : 0;
                if (n_log < 64) begin log_op[n_log] = op; log_b[n_log] = b; end
                n_log++;
                repeat (2) @(negedge clk);
                prim_done = 1'b1;
                if (prim_cnt == arb_sel) prim_arb = 1'b1;
                if (op == int'(OP_WRITE)) begin
                    if (wr_cnt == nack_sel) prim_nack = 1'b1;
                    wr_cnt++;
                end else if (op == int'(OP_READ)) begin
                    prim_rdata = (model_blk && rd_cnt == 0) ? 8'(blk_rsp) : pat(rd_cnt);
                    rd_cnt++;
                end
                prim_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(OFS_STAT, s);
            if (!s[0]) return;
        end
        chk("R2 busy never cleared", 1, 0);
    endtask

    task automatic model_reset(input bit blk, input int cnt);
        n_log = 0; wr_cnt = 0; rd_cnt = 0; prim_cnt = 0;
        model_blk = blk; blk_rsp = cnt;
    endtask

    task automatic ex(input prim_op_e op, input int b);
        exp_op[n_exp] = int'(op); exp_b[n_exp] = b; n_exp++;
    endtask

    // Expected primitive list, written from R3-R8.
    task automatic build_exp(input logic [2:0] pr, input bit r, input int len);
        n_exp = 0;
        ex(OP_START, 0);
        if (pr == PR_QUICK) begin
            ex(OP_WRITE, {TGT, r});
        end else if (pr == PR_BYTE) begin
            ex(OP_WRITE, {TGT, r});
            if (r) ex(OP_READ, 1); else ex(OP_WRITE, CMD);
        end else if (!r) begin
            ex(OP_WRITE, {TGT, 1'b0}); ex(OP_WRITE, CMD);
            if (pr == PR_BDATA) ex(OP_WRITE, 8'h3E);
            if (pr == PR_WORD) begin ex(OP_WRITE, 8'h3E); ex(OP_WRITE, 8'h9D); end
            if (pr == PR_BLOCK) begin
                ex(OP_WRITE, len);
                for (int i = 0; i < len; i++) ex(OP_WRITE, 8'hC0 + i);
            end
        end else begin
            ex(OP_WRITE, {TGT, 1'b0}); ex(OP_WRITE, CMD);
            ex(OP_RSTART, 0); ex(OP_WRITE, {TGT, 1'b1});
            if (pr == PR_BDATA) ex(OP_READ, 1);
            if (pr == PR_WORD) begin ex(OP_READ, 0); ex(OP_READ, 1); end
            if (pr == PR_BLOCK) begin
                ex(OP_READ, 0);
                for (int k = 1; k <= len; k++) ex(OP_READ, (k == len) ? 1 : 0);
            end
        end
        ex(OP_STOP, 0);
    endtask

    function automatic int seq_mismatch();
        int m = (n_log != n_exp) ? 1 : 0;
        for (int i = 0; i < n_exp && i < n_log && i < 64; i++)
            if (log_op[i] != exp_op[i] || log_b[i] != exp_b[i]) m++;
        return m;
    endfunction

    task automatic setup(input logic [2:0] pr, input bit r, input int len, input int cnt);
        logic [7:0] dmy;
        model_reset(pr == PR_BLOCK, cnt);
        wr(OFS_ADDR, {TGT, r});
        wr(OFS_CMD, CMD);
        wr(OFS_D0, (pr == PR_BLOCK) ? 8'(len) : 8'h3E);
        wr(OFS_D1, 8'h9D);
        if (pr == PR_BLOCK && !r) begin
            rd(OFS_CTRL, dmy);
            for (int i = 0; i < len && i < 32; i++) wr(OFS_BLK, 8'hC0 + i);
        end
    endtask

    task automatic launch(input logic [2:0] pr);
        wr(OFS_CTRL, {1'b0, 1'b1, 1'b0, pr, 2'b00});
    endtask

    task automatic run(input logic [2:0] pr, input bit r, input int len, input string tag);
        logic [7:0] v, w;
        int m;
        setup(pr, r, len, len);
        launch(pr);
        wait_idle();
        build_exp(pr, r, len);
        chk({tag, " primitive sequence"}, seq_mismatch(), 0);
        rd(OFS_STAT, v);
        chk("R13 done flag after transaction", v, 8'h02);
        if (r && pr != PR_QUICK) begin
            rd(OFS_D0, v); rd(OFS_D1, w);
            if (pr == PR_BYTE || pr == PR_BDATA) chk({tag, " data0"}, v, pat(0));
            if (pr == PR_WORD) chk("R6 word low/high", {w, v}, {pat(1), pat(0)});
            if (pr == PR_BLOCK) begin
                chk("R8 block count in data0", v, len);
                rd(OFS_CTRL, v);
                m = 0;
                for (int k = 1; k <= len; k++) begin
                    rd(OFS_BLK, v);
                    if (v != pat(k)) m++;
                end
                chk("R8 block payload", m, 0);
            end
        end
        wr(OFS_STAT, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values and unused offset
        rd(OFS_STAT, v); chk("R1 status reset", v, 0);
        rd(OFS_CTRL, v); chk("R1 control reset", v, 0);
        rd(3'd1, v);     chk("R1 offset 1 reads zero", v, 0);
        chk("R14 irq low at reset", irq, 0);
        wr(OFS_CTRL, 8'hBF);
        rd(OFS_CTRL, v); chk("R1 control undecoded bits", v, 8'h1D);
        wr(OFS_CTRL, 8'h00);

        // R9 block port pointer
        rd(OFS_CTRL, v);
        wr(OFS_BLK, 8'h11); wr(OFS_BLK, 8'h22); wr(OFS_BLK, 8'h33);
        rd(OFS_CTRL, v);
        rd(OFS_BLK, v); chk("R9 first entry", v, 8'h11);
        rd(OFS_BLK, v); chk("R9 auto-increment", v, 8'h22);
        rd(OFS_CTRL, v);
        rd(OFS_BLK, v); chk("R9 control read rewinds", v, 8'h11);

        // R3-R6 sweep over protocol and direction
        for (int r = 0; r < 2; r++) begin
            run(PR_QUICK, r[0], 0, "R3 quick");
            run(PR_BYTE,  r[0], 0, "R4 byte");
            run(PR_BDATA, r[0], 0, r ? "R6 byte-data read" : "R5 byte-data write");
            run(PR_WORD,  r[0], 0, r ? "R6 word read" : "R5 word write");
        end
        // R7/R8 block lengths 1..32, both directions
        for (int len = 1; len <= 32; len++) begin
            run(PR_BLOCK, 1'b0, len, "R7 block write");
            run(PR_BLOCK, 1'b1, len, "R8 block read");
        end

        // R7 invalid counts
        for (int c = 0; c < 2; c++) begin
            setup(PR_BLOCK, 1'b0, c ? 33 : 0, 0);
            launch(PR_BLOCK); wait_idle();
            chk("R7 bad count no bus activity", n_log, 0);
            rd(OFS_STAT, v); chk("R7 bad count failed flag", v, 8'h12);
            wr(OFS_STAT, 8'hFF);
        end

        // R12 unsupported codes
        for (int p = 4; p < 8; p++) begin
            if (p == 5) continue;
            setup(3'(p), 1'b0, 0, 0);
            launch(3'(p)); wait_idle();
            chk("R12 no primitive for bad code", n_log, 0);
            rd(OFS_STAT, v); chk("R12 failed flag", v, 8'h12);
            wr(OFS_STAT, 8'hFF);
        end

        // R8 invalid count received
        setup(PR_BLOCK, 1'b1, 4, 40);
        launch(PR_BLOCK); wait_idle();
        n_exp = 0;
        ex(OP_START, 0); ex(OP_WRITE, {TGT, 1'b0}); ex(OP_WRITE, CMD);
        ex(OP_RSTART, 0); ex(OP_WRITE, {TGT, 1'b1}); ex(OP_READ, 0); ex(OP_STOP, 0);
        chk("R8 bad count goes to stop", seq_mismatch(), 0);
        rd(OFS_STAT, v); chk("R8 bad count failed flag", v, 8'h12);
        rd(OFS_D0, v);   chk("R8 bad count kept in data0", v, 40);
        wr(OFS_STAT, 8'hFF);

        // R10 nack on address, then on a data byte
        setup(PR_WORD, 1'b0, 0, 0); nack_sel = 0;
        launch(PR_WORD); wait_idle();
        n_exp = 0; ex(OP_START, 0); ex(OP_WRITE, {TGT, 1'b0}); ex(OP_STOP, 0);
        chk("R10 address nack aborts", seq_mismatch(), 0);
        rd(OFS_STAT, v); chk("R10 no-response flag", v, 8'h06);
        wr(OFS_STAT, 8'hFF);
        setup(PR_BDATA, 1'b0, 0, 0); nack_sel = 2;
        launch(PR_BDATA); wait_idle();
        build_exp(PR_BDATA, 1'b0, 0);
        chk("R10 data nack then stop", seq_mismatch(), 0);
        rd(OFS_STAT, v); chk("R10 no-response flag on data", v, 8'h06);
        nack_sel = -1;

        // R2 launch ignored while a flag is pending; R13 selective clear
        model_reset(0, 0);
        launch(PR_QUICK);
        repeat (10) @(negedge clk);
        chk("R2 launch ignored with flag set", n_log, 0);
        rd(OFS_STAT, v); chk("R2 status unchanged", v, 8'h06);
        wr(OFS_STAT, 8'h04);
        rd(OFS_STAT, v); chk("R13 write-one clears only that bit", v, 8'h02);
        wr(OFS_STAT, 8'hFF);

        // R11 arbitration lost at the address byte
        setup(PR_BYTE, 1'b0, 0, 0); arb_sel = 1;
        launch(PR_BYTE); wait_idle();
        chk("R11 no stop after arbitration loss", n_log, 2);
        rd(OFS_STAT, v); chk("R11 collision flag", v, 8'h0A);
        arb_sel = -1;
        wr(OFS_STAT, 8'hFF);

        // R2 busy and writes ignored while busy
        setup(PR_WORD, 1'b0, 0, 0);
        launch(PR_WORD);
        rd(OFS_STAT, v); chk("R2 busy after launch", v[0], 1);
        wr(OFS_D1, 8'h00);
        wr(OFS_CTRL, 8'h41);
        wait_idle();
        rd(OFS_D1, v); chk("R2 data write ignored while busy", v, 8'h9D);
        rd(OFS_CTRL, v); chk("R2 control write ignored while busy", v, 8'h0C);
        build_exp(PR_WORD, 1'b0, 0);
        chk("R2 second launch ignored while busy", seq_mismatch(), 0);

        // R14 interrupt gating
        @(negedge clk); chk("R14 irq low with enable clear", irq, 0);
        wr(OFS_CTRL, 8'h01);
        @(negedge clk); chk("R14 irq high with done and enable", irq, 1);
        wr(OFS_STAT, 8'hFF);
        @(negedge clk); chk("R14 irq low after clear", irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule